// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor Transfer Engine

The engine sits between interrupt sources and a system memory bus. When a source raises a request together with the address of a transfer descriptor, the engine reads that descriptor from memory, carries out the data movement it describes (a single unit, or a whole block of units), computes the updated descriptor, stores the changed parts back to memory and acknowledges the request. It also decides whether the CPU should see an interrupt for this activation.

Descriptors come in two layouts, picked by a static input. The compact layout uses three longwords and 24-bit addresses. The wide layout uses four longwords and 32-bit addresses. Each descriptor selects its own transfer mode (normal, repeat or block), its unit size (byte, word or longword) and a stepping rule for each address (increment, decrement or fixed). Descriptors can be chained, so that one request processes several descriptors stored one after another. The bus master port carries right-aligned data and a size code. Any word or longword access that is not naturally aligned is broken into smaller aligned cycles.

Top module: `irq_xfer_ctrl`

## Requirements
- R1: While reset is applied and until a request arrives, `mem_req`, `req_ack` and `cpu_irq` are 0.
- R2: Control byte A is `[7:6]` mode (00 normal, 01 repeat, 1x block), `[5:4]` unit size (00 byte, 01 word, 10 longword), `[3:2]` source step and `[1:0]` destination step. A step code of 10 adds the unit size, 11 subtracts it, and 0x leaves the address fixed. In normal mode one unit is moved per request, both addresses step, and the 16-bit count A is decremented.
- R3: Each bus cycle has a size code of 0 (byte), 1 (word) or 2 (longword), and its address is aligned to that size. A unit is cut greedily from its lowest address: a longword piece where 4 bytes remain at a 4-aligned address, otherwise a word piece where 2 bytes remain at an even address, otherwise a byte. So a longword at 4n+2 takes two word cycles, a word at an odd address takes two byte cycles, and a longword at an odd address takes byte, word, byte. Data is right-aligned and little-endian.
- R4: In repeat mode, count A bits `[15:8]` count down once per request. When they reach 0 they reload from bits `[7:0]`, and the address on the area side steps back by size × units. Control byte B is `[7]` chain, `[6]` chain only on zero, `[5]` interrupt every request, and `[4]` area side (1 source, 0 destination).
- R5: In block mode one request moves count A `[7:0]` units, where 0 means 256. After the block the area-side address is restored, the other address keeps its progress, and the 16-bit count B is decremented.
- R6: `cpu_irq` is high only in the `req_ack` cycle. It is high when the last descriptor processed has interrupt-every-request set, or when that descriptor is in normal or block mode and its count reached 0. A count reaching 0 in repeat mode raises no interrupt.
- R7: With the chain bit set, the next descriptor follows directly in memory (12 or 16 bytes on) and is processed within the same request. If chain-only-on-zero is also set, the chain continues only when the count reached 0.
- R8: Writeback writes the longword holding an address only if that address steps. It always writes the counts longword, and in the wide layout it never writes the control longword.
- R9: When a request names the same descriptor address and layout as the last descriptor that completed a request, the descriptor read is skipped and the held copy is used.
- R10: Compact layout: +0 `{A, src[23:0]}`, +4 `{B, dst[23:0]}`, +8 `{countA, countB}`, with addresses wrapping at 24 bits. Wide layout: +0 `{A, B, 16'h0}`, +4 src, +8 dst, +12 `{countA, countB}`.
- R11: While `mem_req` is high and `mem_ack` is low, the address, size, write flag and write data stay unchanged in the next cycle.
- R12: `req_ack` is a one-cycle pulse at the end of the work for a request, and no bus cycle is in progress during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_desc | input | 1 | 1 selects the wide descriptor layout |
| req_valid | input | 1 | Transfer request, held until acknowledged |
| req_desc_addr | input | 32 | Address of the first descriptor for this request |
| req_ack | output | 1 | Request completed |
| cpu_irq | output | 1 | CPU interrupt, valid with req_ack |
| mem_req | output | 1 | Bus cycle requested |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the cycle |
| mem_size | output | 2 | 0 byte, 1 word, 2 longword |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data, valid with mem_ack |
| mem_ack | input | 1 | Bus cycle completes at this edge |

## Verification
The descriptor update that ends a count also settles two things in the same step: whether the chain continues (chain-only-on-zero) and whether the CPU interrupt fires. Both depend on the same zero result. Descriptors whose counts reach 0 on a chosen request, with chain and chain-only-on-zero set, force both decisions onto one update. The result is judged from the interrupt level at acknowledge, the exact number of bus cycles, and a byte-by-byte comparison of the whole memory against a reference model. Random bus latency, including acknowledges in the first cycle of a request, checks that split pieces and skipped writebacks still add up to the expected cycle count.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam int unsigned DXC_AW = 32;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] MD_NORMAL = 2'd0;
  localparam logic [1:0] MD_REPEAT = 2'd1;
  localparam logic [1:0] STEP_INC = 2'b10;
  localparam logic [1:0] STEP_DEC = 2'b11;

  typedef struct packed {
    logic [7:0]  ca;
    logic [7:0]  cb;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cra;
    logic [15:0] crb;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DRD, S_RD, S_WR, S_STEP, S_UPD, S_WB, S_DONE
  } xst_e;

  function automatic logic [1:0] size_shift(logic [1:0] sz);
    return (sz == SZ_BYTE) ? 2'd0 : (sz == SZ_WORD) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [2:0] unit_bytes(logic [1:0] sz);
    return 3'd1 << size_shift(sz);
  endfunction

  function automatic logic [31:0] step_of(logic [1:0] code, logic [1:0] sz);
    logic [31:0] ub;
    ub = {29'd0, unit_bytes(sz)};
    if (code == STEP_INC)      return ub;
    else if (code == STEP_DEC) return -ub;
    else                       return 32'd0;
  endfunction
endpackage

// File: rtl/dxc_piece.sv
module dxc_piece #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [2:0]    off,
  input  logic [2:0]    ubytes,
  input  logic [AW-1:0] amask,
  output logic [AW-1:0] addr,
  output logic [1:0]    size,
  output logic [2:0]    nbytes
);
  logic [2:0] rem;

  always_comb begin
    rem  = ubytes - off;
    addr = (base + {{(AW-3){1'b0}}, off}) & amask;
    if (rem >= 3'd4 && addr[1:0] == 2'b00) begin
      size   = 2'd2;
      nbytes = 3'd4;
    end else if (rem >= 3'd2 && !addr[0]) begin
      size   = 2'd1;
      nbytes = 3'd2;
    end else begin
      size   = 2'd0;
      nbytes = 3'd1;
    end
  end
endmodule

// File: rtl/dxc_update.sv
module dxc_update
  import dxc_pkg::*;
(
  input  desc_t       cur,
  input  logic [31:0] amask,
  output desc_t       nxt,
  output logic        zero,
  output logic        irq_want
);
  logic [1:0]  mode, sz, rcode;
  logic [8:0]  nblk;
  logic [31:0] roff, rs, rback;
  logic [7:0]  rcnt;
  logic        side_src, each;

  always_comb begin
    mode     = cur.ca[7:6];
    sz       = cur.ca[5:4];
    side_src = cur.cb[4];
    each     = cur.cb[5];
    nblk     = {cur.cra[7:0] == 8'd0, cur.cra[7:0]};
    roff     = {23'd0, nblk} << size_shift(sz);
    rs       = side_src ? cur.src : cur.dst;
    rcode    = side_src ? cur.ca[3:2] : cur.ca[1:0];
    if (rcode == STEP_INC)      rback = (rs - roff) & amask;
    else if (rcode == STEP_DEC) rback = (rs + roff) & amask;
    else                        rback = rs;

    nxt      = cur;
    rcnt     = cur.cra[15:8] - 8'd1;
    zero     = 1'b0;
    irq_want = each;
    case (mode)
      MD_NORMAL: begin
        nxt.cra  = cur.cra - 16'd1;
        zero     = (nxt.cra == 16'd0);
        irq_want = zero | each;
      end
      MD_REPEAT: begin
        zero = (rcnt == 8'd0);
        if (zero) begin
          nxt.cra[15:8] = cur.cra[7:0];
          if (side_src) nxt.src = rback;
          else          nxt.dst = rback;
        end else begin
          nxt.cra[15:8] = rcnt;
        end
      end
      default: begin
        if (side_src) nxt.src = rback;
        else          nxt.dst = rback;
        nxt.crb  = cur.crb - 16'd1;
        zero     = (nxt.crb == 16'd0);
        irq_want = zero | each;
      end
    endcase
  end
endmodule

// File: rtl/irq_xfer_ctrl.sv
module irq_xfer_ctrl
  import dxc_pkg::*;
#(
  parameter int AW       = DXC_AW,
  parameter int SHORT_AW = 24,
  parameter int RST_SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          long_desc,
  input  logic          req_valid,
  input  logic [AW-1:0] req_desc_addr,
  output logic          req_ack,
  output logic          cpu_irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam logic [AW-1:0] SHORT_MASK = AW'((64'd1 << SHORT_AW) - 64'd1);
  localparam logic [AW-1:0] FULL_MASK  = '1;

  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_SYNC-1];

  xst_e          st, st_n;
  desc_t         d, d_n, upd_d;
  logic [AW-1:0] daddr, daddr_n, cache_addr, caddr_n;
  logic [1:0]    idx, idx_n, last_idx;
  logic [2:0]    off, off_n, ub, acc_off;
  logic [31:0]   dbuf, dbuf_n, piece_data, piece_mask;
  logic [8:0]    left, left_n;
  logic          zero_q, zero_n, irqw_q, irqw_n, irq_q, irq_n;
  logic          cache_ok, cok_n, cache_long, clong_n;
  logic          upd_zero, upd_irq, wb_need, chain_go;
  logic [31:0]   wb_data;
  logic [AW-1:0] amask, p_base, p_addr;
  logic [1:0]    p_size;
  logic [2:0]    p_nbytes;

  assign amask    = long_desc ? FULL_MASK : SHORT_MASK;
  assign last_idx = long_desc ? 2'd3 : 2'd2;
  assign ub       = unit_bytes(d.ca[5:4]);
  assign p_base   = (st == S_WR) ? d.dst : d.src;
  assign acc_off  = off + p_nbytes;
  assign piece_mask = (p_nbytes == 3'd1) ? 32'h0000_00FF :
                      (p_nbytes == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign chain_go = d.cb[7] && (!d.cb[6] || zero_q);

  dxc_piece #(.AW(AW)) piece_i (
    .base(p_base), .off(off), .ubytes(ub), .amask(amask),
    .addr(p_addr), .size(p_size), .nbytes(p_nbytes)
  );

  dxc_update update_i (
    .cur(d), .amask(amask), .nxt(upd_d), .zero(upd_zero), .irq_want(upd_irq)
  );

  function automatic logic [8:0] units_of(desc_t x);
    if (x.ca[7]) return {x.cra[7:0] == 8'd0, x.cra[7:0]};
    return 9'd1;
  endfunction

  function automatic desc_t load_word(desc_t cur, logic [1:0] k, logic lng, logic [31:0] w);
    desc_t r;
    r = cur;
    if (!lng) begin
      case (k)
        2'd0:    begin r.ca = w[31:24]; r.src = {8'h00, w[23:0]}; end
        2'd1:    begin r.cb = w[31:24]; r.dst = {8'h00, w[23:0]}; end
        default: begin r.cra = w[31:16]; r.crb = w[15:0]; end
      endcase
    end else begin
      case (k)
        2'd0:    begin r.ca = w[31:24]; r.cb = w[23:16]; end
        2'd1:    r.src = w;
        2'd2:    r.dst = w;
        default: begin r.cra = w[31:16]; r.crb = w[15:0]; end
      endcase
    end
    return r;
  endfunction

  always_comb begin
    wb_need = 1'b1;
    wb_data = {d.cra, d.crb};
    if (!long_desc) begin
      case (idx)
        2'd0:    begin wb_need = d.ca[3]; wb_data = {d.ca, d.src[23:0]}; end
        2'd1:    begin wb_need = d.ca[1]; wb_data = {d.cb, d.dst[23:0]}; end
        default: ;
      endcase
    end else begin
      case (idx)
        2'd0:    wb_need = 1'b0;
        2'd1:    begin wb_need = d.ca[3]; wb_data = d.src; end
        2'd2:    begin wb_need = d.ca[1]; wb_data = d.dst; end
        default: ;
      endcase
    end
  end

  always_comb begin
    st_n = st;       d_n = d;         daddr_n = daddr;  idx_n = idx;
    off_n = off;     dbuf_n = dbuf;   left_n = left;    zero_n = zero_q;
    irqw_n = irqw_q; irq_n = irq_q;   cok_n = cache_ok;
    caddr_n = cache_addr;             clong_n = cache_long;
    mem_req = 1'b0;  mem_we = 1'b0;   mem_addr = '0;    mem_size = 2'd0;
    mem_wdata = 32'd0;
    piece_data = mem_rdata & piece_mask;
    case (st)
      S_IDLE: begin
        if (req_valid) begin
          daddr_n = req_desc_addr;
          idx_n   = 2'd0;
          off_n   = 3'd0;
          dbuf_n  = 32'd0;
          if (cache_ok && cache_addr == req_desc_addr && cache_long == long_desc) begin
            st_n   = S_RD;
            left_n = units_of(d);
          end else begin
            st_n  = S_DRD;
            cok_n = 1'b0;
          end
        end
      end
      S_DRD: begin
        mem_req  = 1'b1;
        mem_addr = daddr + {{(AW-4){1'b0}}, idx, 2'b00};
        mem_size = 2'd2;
        if (mem_ack) begin
          d_n = load_word(d, idx, long_desc, mem_rdata);
          if (idx == last_idx) begin
            st_n   = S_RD;
            left_n = units_of(d_n);
          end else begin
            idx_n = idx + 2'd1;
          end
        end
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = p_addr;
        mem_size = p_size;
        if (mem_ack) begin
          dbuf_n = dbuf | (piece_data << {off, 3'b000});
          if (acc_off == ub) begin
            off_n = 3'd0;
            st_n  = S_WR;
          end else begin
            off_n = acc_off;
          end
        end
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = p_addr;
        mem_size  = p_size;
        mem_wdata = (dbuf >> {off, 3'b000}) & piece_mask;
        if (mem_ack) begin
          if (acc_off == ub) begin
            off_n = 3'd0;
            st_n  = S_STEP;
          end else begin
            off_n = acc_off;
          end
        end
      end
      S_STEP: begin
        d_n.src = (d.src + step_of(d.ca[3:2], d.ca[5:4])) & amask;
        d_n.dst = (d.dst + step_of(d.ca[1:0], d.ca[5:4])) & amask;
        left_n  = left - 9'd1;
        dbuf_n  = 32'd0;
        st_n    = (left == 9'd1) ? S_UPD : S_RD;
      end
      S_UPD: begin
        d_n    = upd_d;
        zero_n = upd_zero;
        irqw_n = upd_irq;
        idx_n  = 2'd0;
        st_n   = S_WB;
      end
      S_WB: begin
        mem_req   = wb_need;
        mem_we    = 1'b1;
        mem_addr  = daddr + {{(AW-4){1'b0}}, idx, 2'b00};
        mem_size  = 2'd2;
        mem_wdata = wb_data;
        if (!wb_need || mem_ack) begin
          if (idx != last_idx) begin
            idx_n = idx + 2'd1;
          end else if (chain_go) begin
            daddr_n = daddr + (long_desc ? AW'(16) : AW'(12));
            idx_n   = 2'd0;
            cok_n   = 1'b0;
            st_n    = S_DRD;
          end else begin
            irq_n   = irqw_q;
            cok_n   = 1'b1;
            caddr_n = daddr;
            clong_n = long_desc;
            st_n    = S_DONE;
          end
        end
      end
      S_DONE: begin
        irq_n = 1'b0;
        st_n  = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st <= S_IDLE;  d <= '0;        daddr <= '0;     idx <= '0;
      off <= '0;     dbuf <= '0;     left <= '0;      zero_q <= 1'b0;
      irqw_q <= 1'b0; irq_q <= 1'b0; cache_ok <= 1'b0;
      cache_addr <= '0; cache_long <= 1'b0;
    end else begin
      st <= st_n;    d <= d_n;       daddr <= daddr_n; idx <= idx_n;
      off <= off_n;  dbuf <= dbuf_n; left <= left_n;   zero_q <= zero_n;
      irqw_q <= irqw_n; irq_q <= irq_n; cache_ok <= cok_n;
      cache_addr <= caddr_n; cache_long <= clong_n;
    end
  end

  assign req_ack = (st == S_DONE);
  assign cpu_irq = irq_q;
endmodule

// File: rtl/irq_xfer_ctrl_chk.sv
module irq_xfer_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ack,
  input logic        cpu_irq,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [1:0]  mem_size,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)
                               && $stable(mem_we) && $stable(mem_wdata))); // R11
  AST_PIECE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_size == 2'd2) ? (mem_addr[1:0] == 2'b00) :
                 (mem_size == 2'd1) ? !mem_addr[0] : 1'b1)); // R3
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != 2'd3)); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R12
  AST_NO_BUS_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !mem_req); // R12
  AST_IRQ_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> req_ack); // R6
endmodule

bind irq_xfer_ctrl irq_xfer_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .cpu_irq(cpu_irq),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/irq_xfer_ctrl_tb.sv
module irq_xfer_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEMSZ = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic long_desc = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_desc_addr = 32'd0;
  logic req_ack, cpu_irq, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic [31:0] mem_rdata = 32'd0;
  logic mem_ack = 1'b0;

  logic [7:0] dut_mem [0:MEMSZ-1];
  logic [7:0] ref_mem [0:MEMSZ-1];
  int checks = 0;
  int errors = 0;
  int bus_cnt = 0;

  logic [7:0]  m_ca, m_cb;
  logic [31:0] m_src, m_dst;
  logic [15:0] m_cra, m_crb;
  bit          m_cok = 0;
  logic [31:0] m_caddr = 32'd0;
  bit          m_clong = 0;

  irq_xfer_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .long_desc(long_desc), .req_valid(req_valid),
    .req_desc_addr(req_desc_addr), .req_ack(req_ack), .cpu_irq(cpu_irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    logic [11:0] a;
    a = mem_addr[11:0];
    mem_ack = ($urandom % 3) != 0;
    case (mem_size)
      2'd0:    mem_rdata = {24'd0, dut_mem[a]};
      2'd1:    mem_rdata = {16'd0, dut_mem[a + 12'd1], dut_mem[a]};
      default: mem_rdata = {dut_mem[a + 12'd3], dut_mem[a + 12'd2], dut_mem[a + 12'd1], dut_mem[a]};
    endcase
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      bus_cnt <= bus_cnt + 1;
      if (mem_we) begin
        for (int i = 0; i < (1 << mem_size); i++)
          dut_mem[mem_addr[11:0] + 12'(i)] <= mem_wdata[8*i +: 8];
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [31:0] a);
    logic [11:0] i;
    i = a[11:0];
    return {ref_mem[i + 12'd3], ref_mem[i + 12'd2], ref_mem[i + 12'd1], ref_mem[i]};
  endfunction

  function automatic logic [31:0] dut_rd32(input logic [31:0] a);
    logic [11:0] i;
    i = a[11:0];
    return {dut_mem[i + 12'd3], dut_mem[i + 12'd2], dut_mem[i + 12'd1], dut_mem[i]};
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] v, input bit both);
    for (int b = 0; b < 4; b++) begin
      ref_mem[a[11:0] + 12'(b)] = v[8*b +: 8];
      if (both) dut_mem[a[11:0] + 12'(b)] = v[8*b +: 8];
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input bit lng, input logic [7:0] ca,
                          input logic [7:0] cb, input logic [31:0] s, input logic [31:0] dd,
                          input logic [15:0] cra, input logic [15:0] crb);
    if (!lng) begin
      wr32(a, {ca, s[23:0]}, 1);
      wr32(a + 4, {cb, dd[23:0]}, 1);
      wr32(a + 8, {cra, crb}, 1);
    end else begin
      wr32(a, {ca, cb, 16'h0}, 1);
      wr32(a + 4, s, 1);
      wr32(a + 8, dd, 1);
      wr32(a + 12, {cra, crb}, 1);
    end
  endtask

  function automatic int pieces(input logic [31:0] a, input int ub);
    int n = 0;
    int o = 0;
    while (o < ub) begin
      logic [31:0] x;
      int r;
      x = a + o;
      r = ub - o;
      if (r >= 4 && x[1:0] == 2'b00) o += 4;
      else if (r >= 2 && !x[0]) o += 2;
      else o += 1;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] stepv(input logic [1:0] code, input int ub);
    if (code == 2'b10) return 32'(ub);
    if (code == 2'b11) return -32'(ub);
    return 32'd0;
  endfunction

  task automatic model_run(input logic [31:0] da0, input bit lng, output bit irq, output int cyc);
    logic [31:0] da, amask, roff;
    bit first, more, zero, irqw, side;
    int sh, ub, nun;
    logic [1:0] rcode;
    logic [7:0] c8;
    da = da0; first = 1; more = 1; cyc = 0; irq = 0;
    amask = lng ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
    while (more) begin
      if (!(first && m_cok && m_caddr == da && m_clong == lng)) begin
        if (!lng) begin
          m_ca = rd32(da)[31:24];  m_src = {8'h0, rd32(da)[23:0]};
          m_cb = rd32(da + 4)[31:24]; m_dst = {8'h0, rd32(da + 4)[23:0]};
          {m_cra, m_crb} = rd32(da + 8);
          cyc += 3;
        end else begin
          m_ca = rd32(da)[31:24]; m_cb = rd32(da)[23:16];
          m_src = rd32(da + 4); m_dst = rd32(da + 8);
          {m_cra, m_crb} = rd32(da + 12);
          cyc += 4;
        end
        m_cok = 0;
      end
      first = 0;
      sh  = (m_ca[5:4] == 2'd0) ? 0 : (m_ca[5:4] == 2'd1) ? 1 : 2;
      ub  = 1 << sh;
      nun = m_ca[7] ? ((m_cra[7:0] == 0) ? 256 : int'(m_cra[7:0])) : 1;
      for (int u = 0; u < nun; u++) begin
        logic [7:0] tmp [4];
        for (int b = 0; b < ub; b++) tmp[b] = ref_mem[12'(m_src + 32'(b))];
        for (int b = 0; b < ub; b++) ref_mem[12'(m_dst + 32'(b))] = tmp[b];
        cyc += pieces(m_src, ub) + pieces(m_dst, ub);
        m_src = (m_src + stepv(m_ca[3:2], ub)) & amask;
        m_dst = (m_dst + stepv(m_ca[1:0], ub)) & amask;
      end
      side  = m_cb[4];
      rcode = side ? m_ca[3:2] : m_ca[1:0];
      roff  = ((m_cra[7:0] == 0) ? 32'd256 : {24'd0, m_cra[7:0]}) << sh;
      irqw  = m_cb[5];
      zero  = 0;
      if (m_ca[7:6] == 2'd0) begin
        m_cra = m_cra - 1; zero = (m_cra == 0); irqw = zero | m_cb[5];
      end else if (m_ca[7:6] == 2'd1) begin
        c8 = m_cra[15:8] - 1; zero = (c8 == 0);
        m_cra[15:8] = zero ? m_cra[7:0] : c8;
      end else begin
        m_crb = m_crb - 1; zero = (m_crb == 0); irqw = zero | m_cb[5];
      end
      if (m_ca[7] || (m_ca[7:6] == 2'd1 && zero)) begin
        if (rcode == 2'b10) begin
          if (side) m_src = (m_src - roff) & amask; else m_dst = (m_dst - roff) & amask;
        end else if (rcode == 2'b11) begin
          if (side) m_src = (m_src + roff) & amask; else m_dst = (m_dst + roff) & amask;
        end
      end
      if (!lng) begin
        if (m_ca[3]) begin wr32(da, {m_ca, m_src[23:0]}, 0); cyc++; end
        if (m_ca[1]) begin wr32(da + 4, {m_cb, m_dst[23:0]}, 0); cyc++; end
        wr32(da + 8, {m_cra, m_crb}, 0); cyc++;
      end else begin
        if (m_ca[3]) begin wr32(da + 4, m_src, 0); cyc++; end
        if (m_ca[1]) begin wr32(da + 8, m_dst, 0); cyc++; end
        wr32(da + 12, {m_cra, m_crb}, 0); cyc++;
      end
      more = m_cb[7] && (!m_cb[6] || zero);
      if (more) da = da + (lng ? 16 : 12);
      else begin
        irq = irqw; m_cok = 1; m_caddr = da; m_clong = lng;
      end
    end
  endtask

  task automatic activate(input logic [31:0] da, input bit lng, input string req);
    bit exp_irq, got_irq;
    int exp_cyc, wait_n, mism;
    model_run(da, lng, exp_irq, exp_cyc);
    @(negedge clk);
    long_desc = lng;
    req_desc_addr = da;
    req_valid = 1'b1;
    bus_cnt = 0;
    wait_n = 0;
    got_irq = 0;
    while (wait_n < 8000) begin
      @(negedge clk);
      if (req_ack) break;
      wait_n++;
    end
    if (wait_n >= 8000) check(req, "request timeout", 0, 1);
    got_irq = cpu_irq;
    req_valid = 1'b0;
    check(req, "cpu_irq at ack", got_irq, exp_irq);
    check(req, "bus cycles", bus_cnt, exp_cyc);
    mism = 0;
    for (int i = 0; i < MEMSZ; i++) if (dut_mem[i] !== ref_mem[i]) mism++;
    check(req, "memory bytes differing", mism, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] da, prev_da;
    bit lng, prev_lng;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < MEMSZ; i++) begin
      dut_mem[i] = 8'($urandom);
      ref_mem[i] = dut_mem[i];
    end
    repeat (3) @(negedge clk);
    check("R1", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "mem_req idle", mem_req, 0);
    check("R1", "req_ack idle", req_ack, 0);
    check("R1", "cpu_irq idle", cpu_irq, 0);

    // R2 R6: normal byte move, count 2; interrupt only on the second request
    put_desc(32'h000, 0, 8'b00_00_10_10, 8'h00, 32'h300, 32'h400, 16'd2, 16'd0);
    activate(32'h000, 0, "R2");
    check("R6", "no irq before count ends", cpu_irq, 0);
    activate(32'h000, 0, "R6");
    check("R2", "stepped source written back", dut_rd32(32'h000), {8'b00_00_10_10, 24'h000302});

    // R3 R8 R10: wide layout, longword at 4n+2 source and odd destination, both fixed
    put_desc(32'h020, 1, 8'b00_10_00_00, 8'h00, 32'h502, 32'h601, 16'd5, 16'd0);
    activate(32'h020, 1, "R3");
    check("R3", "split cycle count", bus_cnt, 4 + 2 + 3 + 1);
    // R9: same descriptor again, read skipped
    activate(32'h020, 1, "R9");
    check("R9", "read skipped cycle count", bus_cnt, 2 + 3 + 1);

    // R4: repeat, count 2 of size 2, destination side, word units
    put_desc(32'h040, 0, 8'b01_01_10_10, 8'h00, 32'h700, 32'h801, 16'h0202, 16'd0);
    activate(32'h040, 0, "R4");
    activate(32'h040, 0, "R4");
    check("R4", "repeat area address restored", dut_rd32(32'h044), {8'h00, 24'h000801});
    check("R4", "no irq in repeat at zero", cpu_irq, 0);

    // R5: block of 3 words, source side restored, 2 blocks
    put_desc(32'h060, 1, 8'b10_01_10_11, 8'h10, 32'h900, 32'hA40, 16'h0003, 16'd2);
    activate(32'h060, 1, "R5");
    activate(32'h060, 1, "R5");

    // R7: chain only on zero; first ends its count so the chain proceeds in the same request
    put_desc(32'h080, 0, 8'b00_10_10_10, 8'hC0, 32'hB00, 32'hC00, 16'd1, 16'd0);
    put_desc(32'h08C, 0, 8'b00_00_10_10, 8'h20, 32'hB80, 32'hC80, 16'd4, 16'd0);
    activate(32'h080, 0, "R7");
    put_desc(32'h0A0, 0, 8'b00_10_10_10, 8'hC0, 32'hB40, 32'hC40, 16'd3, 16'd0);
    activate(32'h0A0, 0, "R7");

    prev_da = 32'h0A0; prev_lng = 0;
    for (int t = 0; t < 60; t++) begin
      logic [1:0] md;
      logic [7:0] ca, cb;
      logic [15:0] cra, crb;
      lng = $urandom % 2;
      if (t > 0 && ($urandom % 4) == 0) begin
        activate(prev_da, prev_lng, "R9");
        continue;
      end
      da = 32'h0C0 + 32'(($urandom % 8) * 32);
      md = 2'($urandom % 3);
      ca = {md, 2'($urandom % 3), 2'($urandom), 2'($urandom)};
      cb = {1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 4'h0};
      if (md == 2'd0)      begin cra = 16'(1 + $urandom % 3); crb = 16'd0; end
      else if (md == 2'd1) begin cra = {8'(1 + $urandom % 3), 8'(1 + $urandom % 3)}; crb = 16'd0; end
      else                 begin cra = 16'(1 + $urandom % 4); crb = 16'(1 + $urandom % 3); end
      if (($urandom % 3) == 0) begin
        cb[7] = 1'b1;
        put_desc(da + (lng ? 16 : 12), lng, {2'b00, 2'($urandom % 3), 4'b1010}, 8'h00,
                 32'h240 + 32'($urandom % 64), 32'hD40 + 32'($urandom % 64), 16'(1 + $urandom % 2), 16'd0);
      end
      put_desc(da, lng, ca, cb, 32'h300 + 32'($urandom % 1024), 32'h900 + 32'($urandom % 1024), cra, crb);
      activate(da, lng, cb[7] ? "R7" : (md == 2'd0 ? "R2" : (md == 2'd1 ? "R4" : "R5")));
      prev_da = da; prev_lng = lng;
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule